// File: doc/BRIEF.md
# Keyed Flash Command Sequencer

This block is the command front end of an embedded flash controller, with a plain word-array model standing in for the flash cells. Software loads a byte address and, for word programming, a data word. It then starts an operation by writing the command register. A command is accepted only if that write also carries the unlock key in bits 31:16. Three operations exist: programming one word, erasing one 2 KB block, and erasing the whole array. While an operation runs, its command bit reads back as 1. The bit drops by itself when the operation is done, so polling that bit is the only completion handshake.

Erase and program do not behave the same way. Erase writes all ones into every word it covers. Program ANDs the new data into the stored word, so bits can only go from 1 to 0. A per-block lock input can protect blocks. A command aimed at a locked block, or one with a bad address, is refused at once and leaves a sticky status bit. Raw status is ANDed with a mask to give the masked status and the interrupt line. Writing ones to the masked-status offset clears the matching raw bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset, every register offset 0 to 5 reads 0, no operation is running and `irq` is 0.
- R2: A command-register write whose bits 31:16 differ from 16'hA442 is ignored: the command readback stays 0, the array is unchanged and no status bit is set.
- R3: Command bits are bit 0 for word program, bit 1 for block erase and bit 2 for mass erase, and the running operation reads back on the same bit. If several bits are set, mass erase wins over block erase, and block erase wins over program.
- R4: A keyed word program keeps command bit 0 at 1 for exactly PROG_CYC cycles. It then stores the old word AND the data register at the addressed word and sets status bit 5 (done).
- R5: Programming a word that is not all ones still stores the AND. It also sets status bit 3 (invalid data).
- R6: A block erase at a 2 KB aligned address keeps command bit 1 at 1 for one cycle per word of the block (512). It leaves every word of that block at 32'hFFFFFFFF and sets bit 5. Other blocks are not touched.
- R7: A mass erase keeps command bit 2 at 1 for one cycle per array word. It sets every word to 32'hFFFFFFFF and sets bit 5.
- R8: A program or block erase that targets a block whose `blk_lock` bit is 1 is refused. So is a mass erase while any lock bit is 1. The refusal sets status bit 0 (access violation) right away, no operation starts, and the array is unchanged.
- R9: A program whose address is not word aligned, or lies past the array, is refused and sets status bit 4 (program error). A block erase whose address is not 2 KB aligned, or lies past the array, is refused and sets status bit 2 (erase error).
- R10: A keyed command written while an operation is running is ignored, including its target word.
- R11: Offset 4 reads the raw status and offset 5 reads raw AND the mask at offset 3. `irq` is 1 exactly when that masked value is nonzero.
- R12: Writing offset 5 clears each raw status bit written as 1. Status bits stay set until cleared this way. If an event sets a bit in the same cycle a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register offset for writes and reads (0 address, 1 data, 2 command, 3 mask, 4 raw status, 5 masked status / clear) |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational read of the register at `reg_sel` |
| blk_lock | input | NUM_BLOCKS | One bit per block; 1 forbids program and erase of that block |
| arr_idx | input | log2(array words) | Word index for the array observation port |
| arr_word | output | 32 | Stored word at `arr_idx` |
| irq | output | 1 | OR of masked status |

## Verification
Two functions of this block can land on the same clock edge. The first is the status update when an operation finishes. The second is the software write-1 clear of that same status bit. The bench starts a word program, counts the cycles from the command write, and places the clear write on exactly the edge where the program completes. It then expects the done bit to read 1 afterwards, and expects a later clear of that bit alone to bring it and `irq` back to 0. A second overlap is a keyed command that arrives while an erase is running. The bench judges that case from the array: the word the command targeted must still hold the erased value.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'hA442;

    // register offsets
    localparam logic [2:0] OFS_ADDR = 3'd0;
    localparam logic [2:0] OFS_DATA = 3'd1;
    localparam logic [2:0] OFS_CMD  = 3'd2;
    localparam logic [2:0] OFS_MASK = 3'd3;
    localparam logic [2:0] OFS_RAW  = 3'd4;
    localparam logic [2:0] OFS_STAT = 3'd5;

    // status bit positions
    localparam int ST_ACC  = 0;
    localparam int ST_ERS  = 2;
    localparam int ST_INV  = 3;
    localparam int ST_PRG  = 4;
    localparam int ST_DONE = 5;
    localparam int ST_W    = 6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_MASS  = 2'd3
    } op_e;

    // command request bits -> operation, mass erase first
    function automatic op_e pick_op(input logic [2:0] bits);
        if (bits[2])      return OP_MASS;
        else if (bits[1]) return OP_ERASE;
        else if (bits[0]) return OP_WRITE;
        else              return OP_IDLE;
    endfunction

    // operation -> command readback bits
    function automatic logic [2:0] op_bits(input op_e op);
        case (op)
            OP_WRITE: return 3'b001;
            OP_ERASE: return 3'b010;
            OP_MASS:  return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/fseq_array.sv
module fseq_array #(
    parameter int WORDS = 1024,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [31:0]      rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [31:0]      rdata_b
);
    logic [31:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/fseq_regs.sv
module fseq_regs
    import flash_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [2:0]      reg_sel,
    input  logic [31:0]     wr_data,
    input  logic [2:0]      run_bits,
    input  logic [ST_W-1:0] events,
    output logic            cmd_req,
    output logic [2:0]      req_bits,
    output logic [31:0]     addr_q,
    output logic [31:0]     data_q,
    output logic [31:0]     rd_data,
    output logic            irq
);
    logic [ST_W-1:0] mask_q, raw_q, clr;

    assign cmd_req  = wr_en && reg_sel == OFS_CMD &&
                      wr_data[31:16] == UNLOCK_KEY && |wr_data[2:0];
    assign req_bits = wr_data[2:0];
    assign clr      = (wr_en && reg_sel == OFS_STAT) ? wr_data[ST_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_en && reg_sel == OFS_ADDR) addr_q <= wr_data;
            if (wr_en && reg_sel == OFS_DATA) data_q <= wr_data;
            if (wr_en && reg_sel == OFS_MASK) mask_q <= wr_data[ST_W-1:0];
            // new events win over a clear in the same cycle
            raw_q <= (raw_q & ~clr) | events;
        end
    end

    always_comb begin
        case (reg_sel)
            OFS_ADDR: rd_data = addr_q;
            OFS_DATA: rd_data = data_q;
            OFS_CMD:  rd_data = {29'd0, run_bits};
            OFS_MASK: rd_data = {{(32-ST_W){1'b0}}, mask_q};
            OFS_RAW:  rd_data = {{(32-ST_W){1'b0}}, raw_q};
            OFS_STAT: rd_data = {{(32-ST_W){1'b0}}, raw_q & mask_q};
            default:  rd_data = '0;
        endcase
    end

    assign irq = |(raw_q & mask_q);

    // R12: a completion event is visible next cycle regardless of clears
    p_done_wins_r12: assert property (@(posedge clk) disable iff (rst)
        events[ST_DONE] |=> raw_q[ST_DONE]);

    // R12: without a clear write, no status bit falls
    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_sel == OFS_STAT) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: rtl/fseq_engine.sv
module fseq_engine
    import flash_seq_pkg::*;
#(
    parameter int NUM_BLOCKS  = 2,
    parameter int BLOCK_BYTES = 2048,
    parameter int PROG_CYC    = 16,
    localparam int BLK_WORDS  = BLOCK_BYTES / 4,
    localparam int TOT_WORDS  = NUM_BLOCKS * BLK_WORDS,
    localparam int IDX_W      = $clog2(TOT_WORDS),
    localparam int BLK_SH     = $clog2(BLK_WORDS),
    localparam int BYTE_SH    = $clog2(BLOCK_BYTES),
    localparam int CNT_W      = $clog2(PROG_CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_req,
    input  logic [2:0]            req_bits,
    input  logic [31:0]           addr,
    input  logic [31:0]           data,
    input  logic [NUM_BLOCKS-1:0] lock,
    input  logic [31:0]           mem_rdata,
    output logic [IDX_W-1:0]      mem_raddr,
    output logic                  mem_we,
    output logic [IDX_W-1:0]      mem_waddr,
    output logic [31:0]           mem_wdata,
    output logic [2:0]            run_bits,
    output logic [ST_W-1:0]       events
);
    op_e              op_q, op_d;
    logic [IDX_W-1:0] ptr_q, ptr_d, end_q, end_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [31:0]      dat_q, dat_d;
    logic [IDX_W-1:0] widx, blk_sel;
    logic             in_range, locked;

    assign widx     = addr[IDX_W+1:2];
    assign blk_sel  = widx >> BLK_SH;
    assign in_range = addr < 32'(TOT_WORDS * 4);

    always_comb begin
        locked = 1'b0;
        for (int b = 0; b < NUM_BLOCKS; b++)
            if (blk_sel == IDX_W'(b)) locked = lock[b];
    end

    always_comb begin
        op_d = op_q; ptr_d = ptr_q; end_d = end_q; cnt_d = cnt_q; dat_d = dat_q;
        events = '0; mem_we = 1'b0; mem_waddr = ptr_q; mem_wdata = '1;
        case (op_q)
            OP_IDLE: if (cmd_req) begin
                case (pick_op(req_bits))
                    OP_WRITE:
                        if (!in_range || addr[1:0] != 2'b00) events[ST_PRG] = 1'b1;
                        else if (locked) events[ST_ACC] = 1'b1;
                        else begin
                            op_d = OP_WRITE; ptr_d = widx;
                            cnt_d = CNT_W'(PROG_CYC - 1); dat_d = data;
                        end
                    OP_ERASE:
                        if (!in_range || addr[BYTE_SH-1:0] != '0) events[ST_ERS] = 1'b1;
                        else if (locked) events[ST_ACC] = 1'b1;
                        else begin
                            op_d = OP_ERASE; ptr_d = widx;
                            end_d = widx + IDX_W'(BLK_WORDS - 1);
                        end
                    OP_MASS:
                        if (|lock) events[ST_ACC] = 1'b1;
                        else begin
                            op_d = OP_MASS; ptr_d = '0;
                            end_d = IDX_W'(TOT_WORDS - 1);
                        end
                    default: ;
                endcase
            end
            OP_WRITE:
                if (cnt_q == '0) begin
                    mem_we          = 1'b1;
                    mem_wdata       = mem_rdata & dat_q;
                    events[ST_INV]  = (mem_rdata != '1);
                    events[ST_DONE] = 1'b1;
                    op_d            = OP_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            default: begin
                mem_we = 1'b1;
                if (ptr_q == end_q) begin
                    events[ST_DONE] = 1'b1;
                    op_d            = OP_IDLE;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_IDLE;
            ptr_q <= '0;
            end_q <= '0;
            cnt_q <= '0;
            dat_q <= '0;
        end else begin
            op_q  <= op_d;
            ptr_q <= ptr_d;
            end_q <= end_d;
            cnt_q <= cnt_d;
            dat_q <= dat_d;
        end
    end

    assign mem_raddr = ptr_q;
    assign run_bits  = op_bits(op_q);

    // R10: a keyed request during a program neither restarts it nor swaps its data
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && op_q == OP_WRITE && cnt_q != '0) |=>
            (op_q == OP_WRITE && $stable(dat_q) && $stable(ptr_q)));

    // R8: a refused command leaves the engine idle
    p_refused_idle_r8: assert property (@(posedge clk) disable iff (rst)
        events[ST_ACC] |=> (op_q == OP_IDLE));

    // R4: completion ends the operation on the next cycle
    p_done_ends_r4: assert property (@(posedge clk) disable iff (rst)
        events[ST_DONE] |=> (run_bits == 3'b000));

    // R3: at most one command bit reads back at a time
    p_one_running_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(run_bits));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int NUM_BLOCKS  = 2,
    parameter int BLOCK_BYTES = 2048,
    parameter int PROG_CYC    = 16
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          wr_en,
    input  logic [2:0]                                    reg_sel,
    input  logic [31:0]                                   wr_data,
    output logic [31:0]                                   rd_data,
    input  logic [NUM_BLOCKS-1:0]                         blk_lock,
    input  logic [$clog2(NUM_BLOCKS*BLOCK_BYTES/4)-1:0]   arr_idx,
    output logic [31:0]                                   arr_word,
    output logic                                          irq
);
    localparam int TOT_WORDS = NUM_BLOCKS * BLOCK_BYTES / 4;
    localparam int IDX_W     = $clog2(TOT_WORDS);

    logic            cmd_req;
    logic [2:0]      req_bits, run_bits;
    logic [31:0]     addr_q, data_q, mem_rdata, mem_wdata;
    logic [ST_W-1:0] events;
    logic            mem_we;
    logic [IDX_W-1:0] mem_raddr, mem_waddr;

    fseq_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
        .run_bits(run_bits), .events(events), .cmd_req(cmd_req), .req_bits(req_bits),
        .addr_q(addr_q), .data_q(data_q), .rd_data(rd_data), .irq(irq)
    );

    fseq_engine #(
        .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .PROG_CYC(PROG_CYC)
    ) u_engine (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .req_bits(req_bits),
        .addr(addr_q), .data(data_q), .lock(blk_lock), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .run_bits(run_bits), .events(events)
    );

    fseq_array #(.WORDS(TOT_WORDS)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(mem_raddr), .rdata_a(mem_rdata),
        .raddr_b(arr_idx), .rdata_b(arr_word)
    );
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int NB = 2;
    localparam int BB = 2048;
    localparam int PC = 16;
    localparam int IW = $clog2(NB*BB/4);
    localparam logic [31:0] KEY = 32'hA442_0000;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    reg_sel = 3'd0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NB-1:0] blk_lock = '0;
    logic [IW-1:0] arr_idx = '0;
    logic [31:0]   arr_word;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
        .rd_data(rd_data), .blk_lock(blk_lock), .arr_idx(arr_idx),
        .arr_word(arr_word), .irq(irq)
    );

    // program vectors: byte address, data, expected word, expected invalid flag
    localparam logic [96:0] VEC [5] = '{
        {32'h0000_0000, 32'h1234_5678, 32'h1234_5678, 1'b0},
        {32'h0000_0004, 32'hFFFF_0000, 32'hFFFF_0000, 1'b0},
        {32'h0000_0000, 32'hF0F0_F0F0, 32'h1030_5070, 1'b1},
        {32'h0000_0800, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0},
        {32'h0000_0FFC, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic word(input int idx, output logic [31:0] v);
        arr_idx = IW'(idx);
        #1 v = arr_word;
    endtask

    // counts cycles in which the command register reads nonzero
    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        rd(3'd2, v);
        while (v != 0 && n < 5000) begin
            n++;
            @(negedge clk);
            rd(3'd2, v);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v); chk("R1 reg after reset", v, 0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 0);

        // R7 mass erase
        wr(3'd3, 32'h3F);
        wr(3'd2, KEY | 32'h4);
        wait_idle(n);
        chk("R7 mass erase busy cycles", n, NB*BB/4);
        word(0, v);    chk("R7 word 0 erased", v, ONES);
        word(511, v);  chk("R7 word 511 erased", v, ONES);
        word(1023, v); chk("R7 word 1023 erased", v, ONES);
        rd(3'd4, v);   chk("R7 done status", v, 32'h20);
        chk("R11 irq on done", {31'd0, irq}, 1);
        wr(3'd5, ONES);
        rd(3'd4, v);   chk("R12 clear all", v, 0);
        chk("R12 irq after clear", {31'd0, irq}, 0);

        // R4/R5 program vectors
        for (int i = 0; i < 5; i++) begin
            wr(3'd5, ONES);
            wr(3'd0, VEC[i][96:65]);
            wr(3'd1, VEC[i][64:33]);
            wr(3'd2, KEY | 32'h1);
            wait_idle(n);
            chk("R4 program busy cycles", n, PC);
            word(int'(VEC[i][96:67]), v);
            chk("R4 programmed word", v, VEC[i][32:1]);
            rd(3'd4, v);
            chk("R5 status after program", v, VEC[i][0] ? 32'h28 : 32'h20);
        end

        // R2 wrong key ignored
        wr(3'd5, ONES);
        wr(3'd0, 32'h8); wr(3'd1, 32'h0);
        wr(3'd2, 32'h1234_0001);
        rd(3'd2, v); chk("R2 no busy with bad key", v, 0);
        repeat (20) @(negedge clk);
        word(2, v);  chk("R2 word untouched", v, ONES);
        rd(3'd4, v); chk("R2 no status", v, 0);

        // R3 priority: write+erase bits -> block erase of block 1
        wr(3'd0, 32'h800);
        wr(3'd2, KEY | 32'h3);
        rd(3'd2, v); chk("R3 erase wins over write", v, 32'h2);
        wait_idle(n);
        chk("R6 block erase busy cycles", n, BB/4);
        word(512, v);  chk("R6 block word 512 erased", v, ONES);
        word(1023, v); chk("R6 block word 1023 erased", v, ONES);
        word(0, v);    chk("R6 other block untouched", v, 32'h1030_5070);

        // R8 locked block 0
        blk_lock = 2'b01;
        wr(3'd5, ONES);
        wr(3'd0, 32'h4); wr(3'd1, 32'h0); wr(3'd2, KEY | 32'h1);
        rd(3'd2, v); chk("R8 locked program not started", v, 0);
        rd(3'd4, v); chk("R8 access violation", v, 32'h1);
        word(1, v);  chk("R8 locked word unchanged", v, 32'hFFFF_0000);
        wr(3'd5, ONES);
        wr(3'd0, 32'h0); wr(3'd2, KEY | 32'h2);
        rd(3'd4, v); chk("R8 locked erase refused", v, 32'h1);
        wr(3'd5, ONES);
        wr(3'd2, KEY | 32'h4);
        rd(3'd2, v); chk("R8 mass erase refused", v, 0);
        rd(3'd4, v); chk("R8 mass erase violation", v, 32'h1);
        word(0, v);  chk("R8 array unchanged", v, 32'h1030_5070);
        blk_lock = 2'b00;

        // R9 bad addresses
        wr(3'd5, ONES);
        wr(3'd0, 32'h2); wr(3'd2, KEY | 32'h1);
        rd(3'd4, v); chk("R9 misaligned program", v, 32'h10);
        wr(3'd5, ONES);
        wr(3'd0, 32'h1000); wr(3'd2, KEY | 32'h1);
        rd(3'd4, v); chk("R9 out of range program", v, 32'h10);
        wr(3'd5, ONES);
        wr(3'd0, 32'h400); wr(3'd2, KEY | 32'h2);
        rd(3'd2, v); chk("R9 misaligned erase not started", v, 0);
        rd(3'd4, v); chk("R9 misaligned erase", v, 32'h4);
        wr(3'd5, ONES);
        wr(3'd0, 32'h1000); wr(3'd2, KEY | 32'h2);
        rd(3'd4, v); chk("R9 out of range erase", v, 32'h4);

        // R10 command during busy
        wr(3'd5, ONES);
        wr(3'd0, 32'h800); wr(3'd2, KEY | 32'h2);
        wr(3'd0, 32'h804); wr(3'd1, 32'h0); wr(3'd2, KEY | 32'h1);
        wait_idle(n);
        word(513, v);  chk("R10 busy command ignored", v, ONES);
        rd(3'd4, v);   chk("R10 only done status", v, 32'h20);

        // R11 masking
        wr(3'd3, 32'h20);
        rd(3'd5, v); chk("R11 masked status", v, 32'h20);
        chk("R11 irq masked in", {31'd0, irq}, 1);
        wr(3'd3, 32'h01);
        rd(3'd5, v); chk("R11 masked status off", v, 0);
        chk("R11 irq masked out", {31'd0, irq}, 0);

        // R12 clear on the completion edge
        wr(3'd3, 32'h20);
        wr(3'd5, ONES);
        wr(3'd0, 32'h808); wr(3'd1, 32'h0000_000F);
        wr(3'd2, KEY | 32'h1);
        repeat (PC - 2) @(negedge clk);
        wr(3'd5, ONES);
        rd(3'd4, v); chk("R12 done survives same-cycle clear", v, 32'h20);
        chk("R12 irq after collision", {31'd0, irq}, 1);
        word(514, v); chk("R4 collision program word", v, 32'h0000_000F);
        wr(3'd5, 32'h20);
        rd(3'd4, v); chk("R12 later clear", v, 0);
        chk("R12 irq after later clear", {31'd0, irq}, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule